// File: doc/BRIEF.md
# Configuration Port Address Translator

This host-bridge block turns the two-port configuration access method into configuration transaction descriptors for a bus master engine. The host writes a 32-bit configuration address word to the index port at I/O 0CF8h. That word holds an enable bit, a bus number, a device number, a function number and a doubleword index. A later host access to the data port window (0CFCh to 0CFFh) then becomes a configuration descriptor. The descriptor holds a command code, the address-phase value for the AD lines, active-high byte enables and one-hot IDSEL lines.

The stored bus number is compared with the bridge's own bus number. When they match, a Type 0 address phase is built and the device number is decoded one-hot onto the upper AD lines. When they differ, a Type 1 address phase is built that carries all the routing fields to downstream bridges. Any host access that is neither an index-register access nor an enabled data-port access is passed through unchanged as an ordinary I/O access.

Every host request yields exactly one registered result one cycle later: a configuration descriptor, a pass-through access, or index-register read data. An index-register write is the only exception and yields no output.

Top module: `cfgx_xlate`

## Requirements
- R1: After reset the index register reads as zero, with the enable bit clear, and no output valid is asserted.
- R2: A 4-byte write (io_size_i >= 2) at exactly 0CF8h updates the index register. A 4-byte read at exactly 0CF8h returns, one cycle later on rd_vld_o/rd_data_o, bit 31 enable, bits 23:16 bus, 15:11 device, 10:8 function and 7:2 doubleword, with bits 30:24 and 1:0 read as zero.
- R3: A 1- or 2-byte access, or an access at 0CF9h to 0CFBh, leaves the index register unchanged and is forwarded as an ordinary I/O access.
- R4: A data-port access while the enable bit is clear produces no configuration descriptor and is forwarded as an ordinary I/O access.
- R5: When the stored bus equals own_bus_i, the descriptor is Type 0 (cfg_type1_o = 0): AD[10:8] is the function, AD[7:2] is the doubleword, and AD[15:11] and AD[1:0] are zero.
- R6: In Type 0, device d < 16 sets only AD[16+d] and cfg_idsel_o[d]. A device of 16 or above sets no IDSEL line and leaves AD[31:16] zero.
- R7: When the stored bus differs from own_bus_i, the descriptor is Type 1: AD = {8'h00, bus, device, function, doubleword, 2'b01}, and cfg_idsel_o is zero.
- R8: The configuration command is 4'b1010 for a data-port read and 4'b1011 for a data-port write.
- R9: The byte enables are active-high. They are the mask for the access size (size 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes) shifted left by the data-port offset io_addr_i[1:0]. Bytes that fall beyond bit 3 are dropped. The write data passes through unchanged.
- R10: A pass-through access presents io_addr_i, io_we_i, io_size_i and io_wdata_i unchanged one cycle after the request.
- R11: Each request raises exactly one of cfg_vld_o, pt_vld_o or rd_vld_o for one cycle, one cycle later. An index-register write raises none of them, and no valid is raised without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| own_bus_i | input | 8 | Bus number directly below this bridge |
| io_req_i | input | 1 | Host I/O request strobe, one cycle per access |
| io_we_i | input | 1 | 1 = write, 0 = read |
| io_addr_i | input | IO_AW | Host I/O byte address |
| io_size_i | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| io_wdata_i | input | 32 | Host write data |
| rd_vld_o | output | 1 | Index-register read data valid |
| rd_data_o | output | 32 | Index-register read data |
| cfg_vld_o | output | 1 | Configuration descriptor valid |
| cfg_cmd_o | output | 4 | Configuration command code |
| cfg_type1_o | output | 1 | 1 = Type 1, 0 = Type 0 |
| cfg_addr_o | output | 32 | Address-phase value for AD |
| cfg_idsel_o | output | IDSEL_N | One-hot IDSEL lines (Type 0 only) |
| cfg_be_o | output | 4 | Active-high byte enables |
| cfg_wdata_o | output | 32 | Configuration write data |
| pt_vld_o | output | 1 | Pass-through I/O access valid |
| pt_we_o | output | 1 | Pass-through direction |
| pt_addr_o | output | IO_AW | Pass-through address |
| pt_size_o | output | 2 | Pass-through size |
| pt_wdata_o | output | 32 | Pass-through write data |

## Verification
The hardest situation to reach is the interplay between the stored index word and a later data-port access. Every descriptor field depends on state that only an earlier index write can set, and a wrong write would go unseen until the data access. The stimulus therefore sweeps all 32 device numbers, both function extremes, and matching and non-matching bus numbers. Each case is written as a full index write, read back, and then followed by data-port reads and writes.

Stores that must be ignored are probed the same way. Partial or misaligned writes to the index window are each followed by a full readback. A further sweep of every data-port offset and size combination checks the dropped-byte edge of the byte enables.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [15:0] IDX_PORT  = 16'h0CF8;
  localparam logic [15:0] DATA_PORT = 16'h0CFC;
  localparam logic [3:0]  CMD_CFG_RD = 4'b1010;
  localparam logic [3:0]  CMD_CFG_WR = 4'b1011;

  typedef enum logic [1:0] {
    K_PASS   = 2'd0,
    K_IDX_WR = 2'd1,
    K_IDX_RD = 2'd2,
    K_CFG    = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
  } cfg_idx_t;
endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter int unsigned IO_AW = 16
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [IO_AW-1:0] addr_i,
  input  logic [1:0]       size_i,
  input  logic             en_i,
  output acc_kind_e        kind_o,
  output logic [3:0]       be_o
);
  localparam logic [IO_AW-1:0] IDX_A  = IO_AW'(IDX_PORT);
  localparam logic [IO_AW-1:0] DATA_A = IO_AW'(DATA_PORT);

  logic idx_win, data_win, full, aligned;
  logic [3:0] mask;

  assign idx_win  = addr_i[IO_AW-1:2] == IDX_A[IO_AW-1:2];
  assign data_win = addr_i[IO_AW-1:2] == DATA_A[IO_AW-1:2];
  assign full     = size_i[1];
  assign aligned  = addr_i[1:0] == 2'b00;

  always_comb begin
    kind_o = K_PASS;
    if (req_i) begin
      if (idx_win && full && aligned) kind_o = we_i ? K_IDX_WR : K_IDX_RD;
      else if (data_win && en_i)      kind_o = K_CFG;
    end
  end

  always_comb begin
    unique case (size_i)
      2'd0:    mask = 4'b0001;
      2'd1:    mask = 4'b0011;
      default: mask = 4'b1111;
    endcase
  end

  // bytes shifted past the dword are dropped
  assign be_o = mask << addr_i[1:0];
endmodule

// File: rtl/cfgx_idx_reg.sv
module cfgx_idx_reg
  import cfgx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_idx_t          q_o,
  output logic [DATA_W-1:0] rdval_o
);
  cfg_idx_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (wr_i) begin
      q.en  <= wdata_i[31];
      q.bus <= wdata_i[23:16];
      q.dev <= wdata_i[15:11];
      q.fn  <= wdata_i[10:8];
      q.dw  <= wdata_i[7:2];
    end
  end

  assign q_o     = q;
  assign rdval_o = {q.en, 7'b0, q.bus, q.dev, q.fn, q.dw, 2'b00};
endmodule

// File: rtl/cfgx_phase_gen.sv
module cfgx_phase_gen
  import cfgx_pkg::*;
#(
  parameter int unsigned IDSEL_BASE = 16,
  parameter int unsigned IDSEL_N    = 16
) (
  input  cfg_idx_t          idx_i,
  input  logic [7:0]        own_bus_i,
  output logic              type1_o,
  output logic [DATA_W-1:0] ad_o,
  output logic [IDSEL_N-1:0] idsel_o
);
  logic [DATA_W-1:0] sel_ad;

  assign type1_o = idx_i.bus != own_bus_i;

  for (genvar g = 0; g < IDSEL_N; g++) begin : g_idsel
    assign idsel_o[g] = !type1_o && (idx_i.dev == 5'(g));
    assign sel_ad[IDSEL_BASE+g] = idsel_o[g];
  end
  if (IDSEL_BASE > 0) begin : g_lo
    assign sel_ad[IDSEL_BASE-1:0] = '0;
  end
  if (IDSEL_BASE + IDSEL_N < DATA_W) begin : g_hi
    assign sel_ad[DATA_W-1:IDSEL_BASE+IDSEL_N] = '0;
  end

  always_comb begin
    if (type1_o) ad_o = {8'h00, idx_i.bus, idx_i.dev, idx_i.fn, idx_i.dw, 2'b01};
    else         ad_o = sel_ad | {21'b0, idx_i.fn, idx_i.dw, 2'b00};
  end
endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
  import cfgx_pkg::*;
#(
  parameter int unsigned IO_AW      = 16,
  parameter int unsigned IDSEL_BASE = 16,
  parameter int unsigned IDSEL_N    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         own_bus_i,
  input  logic               io_req_i,
  input  logic               io_we_i,
  input  logic [IO_AW-1:0]   io_addr_i,
  input  logic [1:0]         io_size_i,
  input  logic [31:0]        io_wdata_i,
  output logic               rd_vld_o,
  output logic [31:0]        rd_data_o,
  output logic               cfg_vld_o,
  output logic [3:0]         cfg_cmd_o,
  output logic               cfg_type1_o,
  output logic [31:0]        cfg_addr_o,
  output logic [IDSEL_N-1:0] cfg_idsel_o,
  output logic [3:0]         cfg_be_o,
  output logic [31:0]        cfg_wdata_o,
  output logic               pt_vld_o,
  output logic               pt_we_o,
  output logic [IO_AW-1:0]   pt_addr_o,
  output logic [1:0]         pt_size_o,
  output logic [31:0]        pt_wdata_o
);
  acc_kind_e           kind;
  logic [3:0]          be;
  cfg_idx_t            idx;
  logic [DATA_W-1:0]   idx_rd, ad;
  logic                type1;
  logic [IDSEL_N-1:0]  idsel;

  cfgx_decode #(.IO_AW(IO_AW)) u_dec (
    .req_i (io_req_i),
    .we_i  (io_we_i),
    .addr_i(io_addr_i),
    .size_i(io_size_i),
    .en_i  (idx.en),
    .kind_o(kind),
    .be_o  (be)
  );

  cfgx_idx_reg u_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (kind == K_IDX_WR),
    .wdata_i(io_wdata_i),
    .q_o    (idx),
    .rdval_o(idx_rd)
  );

  cfgx_phase_gen #(.IDSEL_BASE(IDSEL_BASE), .IDSEL_N(IDSEL_N)) u_phase (
    .idx_i    (idx),
    .own_bus_i(own_bus_i),
    .type1_o  (type1),
    .ad_o     (ad),
    .idsel_o  (idsel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o  <= 1'b0;
      cfg_vld_o <= 1'b0;
      pt_vld_o  <= 1'b0;
    end else begin
      rd_vld_o  <= kind == K_IDX_RD;
      cfg_vld_o <= kind == K_CFG;
      pt_vld_o  <= io_req_i && (kind == K_PASS);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o   <= '0;
      cfg_cmd_o   <= '0;
      cfg_type1_o <= 1'b0;
      cfg_addr_o  <= '0;
      cfg_idsel_o <= '0;
      cfg_be_o    <= '0;
      cfg_wdata_o <= '0;
      pt_we_o     <= 1'b0;
      pt_addr_o   <= '0;
      pt_size_o   <= '0;
      pt_wdata_o  <= '0;
    end else begin
      if (kind == K_IDX_RD) rd_data_o <= idx_rd;
      if (kind == K_CFG) begin
        cfg_cmd_o   <= io_we_i ? CMD_CFG_WR : CMD_CFG_RD;
        cfg_type1_o <= type1;
        cfg_addr_o  <= ad;
        cfg_idsel_o <= idsel;
        cfg_be_o    <= be;
        cfg_wdata_o <= io_wdata_i;
      end
      if (io_req_i && kind == K_PASS) begin
        pt_we_o    <= io_we_i;
        pt_addr_o  <= io_addr_i;
        pt_size_o  <= io_size_i;
        pt_wdata_o <= io_wdata_i;
      end
    end
  end
endmodule

// File: rtl/cfgx_xlate_chk.sv
module cfgx_xlate_chk #(
  parameter int unsigned IO_AW   = 16,
  parameter int unsigned IDSEL_N = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [7:0]         own_bus_i,
  input logic               io_req_i,
  input logic               io_we_i,
  input logic [IO_AW-1:0]   io_addr_i,
  input logic               rd_vld_o,
  input logic               cfg_vld_o,
  input logic [3:0]         cfg_cmd_o,
  input logic               cfg_type1_o,
  input logic [31:0]        cfg_addr_o,
  input logic [IDSEL_N-1:0] cfg_idsel_o,
  input logic               pt_vld_o,
  input logic [IO_AW-1:0]   pt_addr_o
);
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_vld_o, cfg_vld_o, pt_vld_o})); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_req_i |=> !(rd_vld_o || cfg_vld_o || pt_vld_o)); // R11
  AST_CFG_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_req_i ##1 cfg_vld_o |-> (cfg_cmd_o[3:1] == 3'b101) && (cfg_cmd_o[0] == $past(io_we_i))); // R8
  AST_T0_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_vld_o && !cfg_type1_o |-> $onehot0(cfg_idsel_o) && (cfg_addr_o[1:0] == 2'b00)
      && (cfg_addr_o[15:11] == 5'd0)); // R6
  AST_T1_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_vld_o && cfg_type1_o |-> (cfg_addr_o[1:0] == 2'b01) && (cfg_idsel_o == '0)); // R7
  AST_T1_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_vld_o && cfg_type1_o && $stable(own_bus_i) |-> cfg_addr_o[23:16] != own_bus_i); // R7
  AST_PT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_req_i ##1 pt_vld_o |-> pt_addr_o == $past(io_addr_i)); // R10
endmodule

bind cfgx_xlate cfgx_xlate_chk #(.IO_AW(IO_AW), .IDSEL_N(IDSEL_N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .own_bus_i  (own_bus_i),
  .io_req_i   (io_req_i),
  .io_we_i    (io_we_i),
  .io_addr_i  (io_addr_i),
  .rd_vld_o   (rd_vld_o),
  .cfg_vld_o  (cfg_vld_o),
  .cfg_cmd_o  (cfg_cmd_o),
  .cfg_type1_o(cfg_type1_o),
  .cfg_addr_o (cfg_addr_o),
  .cfg_idsel_o(cfg_idsel_o),
  .pt_vld_o   (pt_vld_o),
  .pt_addr_o  (pt_addr_o)
);

// File: tb/cfgx_xlate_tb.sv
module cfgx_xlate_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  own_bus_i = 8'h05;
  logic        io_req_i = 1'b0;
  logic        io_we_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic [1:0]  io_size_i = '0;
  logic [31:0] io_wdata_i = '0;
  logic        rd_vld_o, cfg_vld_o, cfg_type1_o, pt_vld_o, pt_we_o;
  logic [31:0] rd_data_o, cfg_addr_o, cfg_wdata_o, pt_wdata_o;
  logic [3:0]  cfg_cmd_o, cfg_be_o;
  logic [15:0] cfg_idsel_o, pt_addr_o;
  logic [1:0]  pt_size_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  cfgx_xlate u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic io(input bit we, input logic [15:0] a, input logic [1:0] sz,
                    input logic [31:0] wd);
    @(negedge clk_i);
    io_req_i = 1'b1; io_we_i = we; io_addr_i = a; io_size_i = sz; io_wdata_i = wd;
    @(negedge clk_i);
    io_req_i = 1'b0;
  endtask

  function automatic logic [31:0] idx_word(bit en, logic [7:0] b, logic [4:0] d,
                                           logic [2:0] f, logic [5:0] w);
    return {en, 7'h00, b, d, f, w, 2'b00};
  endfunction

  function automatic logic [3:0] exp_be(logic [1:0] off, logic [1:0] sz);
    int n;
    logic [7:0] m;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    m = 8'((1 << n) - 1) << off;
    return m[3:0];
  endfunction

  task automatic read_idx(input logic [31:0] exp, input string req);
    io(1'b0, 16'h0CF8, 2'd2, '0);
    chk(rd_vld_o && !cfg_vld_o && !pt_vld_o, req, "index read valid", {29'b0, rd_vld_o, cfg_vld_o, pt_vld_o}, 32'h4);
    chk(rd_data_o == exp, req, "index read data", rd_data_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_ad;
    logic [7:0]  bus;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!rd_vld_o && !cfg_vld_o && !pt_vld_o, "R1", "valids in reset", {29'b0, rd_vld_o, cfg_vld_o, pt_vld_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!rd_vld_o && !cfg_vld_o && !pt_vld_o, "R11", "idle no valid", {29'b0, rd_vld_o, cfg_vld_o, pt_vld_o}, 0);
    read_idx(32'h0, "R1");

    // R4 enable clear: data port forwards
    io(1'b1, 16'h0CF8, 2'd2, idx_word(0, 8'h05, 5'd3, 3'd1, 6'd4) | 32'h7F00_0003);
    read_idx(idx_word(0, 8'h05, 5'd3, 3'd1, 6'd4), "R2");
    for (int o = 0; o < 4; o++) begin
      io(1'b1, 16'h0CFC + 16'(o), 2'd0, 32'hA5A5_0000 + o);
      chk(pt_vld_o && !cfg_vld_o, "R4", "disabled data port forwarded", {30'b0, pt_vld_o, cfg_vld_o}, 32'h2);
      chk(pt_addr_o == 16'h0CFC + 16'(o), "R4", "forward addr", {16'b0, pt_addr_o}, 32'h0CFC + o);
    end

    // R5 R6 R7 R8 sweep of device, function, bus
    for (int d = 0; d < 32; d++) begin
      for (int fi = 0; fi < 2; fi++) begin
        for (int t = 0; t < 2; t++) begin
          logic [2:0] f;
          logic [5:0] w;
          f = fi ? 3'd7 : 3'd0;
          w = 6'(d * 2 + t);
          bus = t ? 8'(8'h05 + 8'(d) + 1) : 8'h05;
          io(1'b1, 16'h0CF8, 2'd2, idx_word(1, bus, 5'(d), f, w));
          read_idx(idx_word(1, bus, 5'(d), f, w), "R2");
          if (t) exp_ad = {8'h00, bus, 5'(d), f, w, 2'b01};
          else   exp_ad = ((d < 16) ? (32'h1 << (16 + d)) : 32'h0) | {21'b0, f, w, 2'b00};
          io(1'b0, 16'h0CFC, 2'd2, '0);
          chk(cfg_vld_o && !pt_vld_o && !rd_vld_o, "R11", "cfg only", {29'b0, rd_vld_o, cfg_vld_o, pt_vld_o}, 32'h2);
          chk(cfg_type1_o == t[0], t ? "R7" : "R5", "type", {31'b0, cfg_type1_o}, t);
          chk(cfg_addr_o == exp_ad, t ? "R7" : (d < 16 ? "R6" : "R5"), "address phase", cfg_addr_o, exp_ad);
          chk(cfg_idsel_o == ((!t && d < 16) ? 16'(1 << d) : 16'h0), "R6", "idsel", {16'b0, cfg_idsel_o},
              (!t && d < 16) ? 32'(1 << d) : 0);
          chk(cfg_cmd_o == 4'b1010, "R8", "read cmd", {28'b0, cfg_cmd_o}, 32'hA);
          io(1'b1, 16'h0CFC, 2'd2, 32'(d) * 32'h0101_0101);
          chk(cfg_cmd_o == 4'b1011 && cfg_vld_o, "R8", "write cmd", {28'b0, cfg_cmd_o}, 32'hB);
          chk(cfg_wdata_o == 32'(d) * 32'h0101_0101, "R9", "write data", cfg_wdata_o, 32'(d) * 32'h0101_0101);
        end
      end
    end

    // R9 byte enables over offset x size x direction
    for (int o = 0; o < 4; o++) begin
      for (int s = 0; s < 4; s++) begin
        for (int we = 0; we < 2; we++) begin
          io(we[0], 16'h0CFC + 16'(o), 2'(s), 32'h1234_5678);
          chk(cfg_vld_o, "R9", "cfg for byte lane access", {31'b0, cfg_vld_o}, 1);
          chk(cfg_be_o == exp_be(2'(o), 2'(s)), "R9", "byte enables", {28'b0, cfg_be_o},
              {28'b0, exp_be(2'(o), 2'(s))});
        end
      end
    end

    // R3 partial or misaligned index accesses ignored by register
    io(1'b1, 16'h0CF8, 2'd2, idx_word(1, 8'h22, 5'd9, 3'd2, 6'd17));
    for (int o = 0; o < 4; o++) begin
      for (int s = 0; s < 4; s++) begin
        if (o != 0 || s < 2) begin
          io(1'b1, 16'h0CF8 + 16'(o), 2'(s), 32'h0000_0000);
          chk(pt_vld_o && !rd_vld_o && !cfg_vld_o, "R3", "partial index forwarded", {29'b0, rd_vld_o, cfg_vld_o, pt_vld_o}, 1);
          chk(pt_size_o == 2'(s) && pt_we_o, "R3", "forward size", {30'b0, pt_size_o}, s);
          read_idx(idx_word(1, 8'h22, 5'd9, 3'd2, 6'd17), "R3");
        end
      end
    end

    // R10 unrelated addresses pass through
    begin
      logic [15:0] addrs [4] = '{16'h0080, 16'h0CF4, 16'h0D00, 16'hFFFC};
      for (int i = 0; i < 4; i++) begin
        io(i[0], addrs[i], 2'(i), 32'hC0DE_0000 + i);
        chk(pt_vld_o && !cfg_vld_o, "R10", "pass valid", {30'b0, pt_vld_o, cfg_vld_o}, 2);
        chk(pt_addr_o == addrs[i] && pt_we_o == i[0] && pt_size_o == 2'(i), "R10", "pass fields",
            {pt_addr_o, 13'b0, pt_we_o, pt_size_o}, {addrs[i], 13'b0, i[0], 2'(i)});
        chk(pt_wdata_o == 32'hC0DE_0000 + i, "R10", "pass data", pt_wdata_o, 32'hC0DE_0000 + i);
      end
    end

    // R11 index write yields no output
    io(1'b1, 16'h0CF8, 2'd3, idx_word(0, 8'h00, 5'd0, 3'd0, 6'd0));
    chk(!rd_vld_o && !cfg_vld_o && !pt_vld_o, "R11", "index write silent", {29'b0, rd_vld_o, cfg_vld_o, pt_vld_o}, 0);
    io(1'b0, 16'h0CFE, 2'd1, '0);
    chk(pt_vld_o && !cfg_vld_o, "R4", "disabled after clear", {30'b0, pt_vld_o, cfg_vld_o}, 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule